// File: doc/BRIEF.md
# Strap-Addressed I2C Byte Slave

This block attaches a chip to a two-wire I2C-compatible bus as a target device. It oversamples SCL and SDA on a fast system clock and never drives the data line high. It only asserts an open-drain pull-down enable. It recognises start and stop conditions and compares the first byte of each transaction against a 7-bit address. The upper nibble of that address is the constant `1001`. The lower three bits come from strap pins. On a match it acknowledges and then exchanges bytes with the local logic in the direction chosen by the R/W bit.

On the user side, received bytes leave as single-cycle `wr_valid` beats carrying `wr_data`. There is no ready: the block does not stretch the clock, so the consumer must take every beat. Transmit bytes are pulled one byte ahead with the single-cycle `rd_req`. The source must present `rd_data` in the same cycle as `rd_req`, and it cannot apply back-pressure. A `start_pulse` with `txn_rw` marks each transaction that is addressed to this device.

Two rules protect the bus. First, a watchdog abandons any transaction in which SDA stays unchanged for `TIMEOUT_CYC` system clocks. Second, the strap pins are trusted only after they have addressed the device twice. Their value is captured at the second matching address byte and frozen for the rest of time after reset.

Top module: `i2c_strap_slave`

## Requirements
- R1: A first byte equal to {1001, strap, R/W} (address MSB first, R/W last) is acknowledged: `sda_oe` is 1 while SCL is high for the ninth clock, and `sda_oe` only rises while SCL is low.
- R2: A first byte with a different address is not acknowledged, and `sda_oe` stays 0 until the next start condition.
- R3: In a write transaction (R/W = 0), every received byte appears MSB first as one `wr_valid` cycle with `wr_data`, and it is acknowledged.
- R4: In a read transaction (R/W = 1), `rd_req` pulses once after the address byte and once after each master ACK. The byte sampled with `rd_req` is driven MSB first, with `sda_oe` = 1 for each 0 bit, and SDA is released during the master's acknowledge slot.
- R5: A master NACK (SDA high on the ninth clock of a read byte) ends driving: no further `rd_req` is issued and `sda_oe` stays 0 until a new start.
- R6: A start or stop condition in the middle of a byte discards the partial byte and restarts address reception.
- R7: If the block is inside a transaction and SDA does not change for `TIMEOUT_CYC` clocks, `sda_oe` is released and the block waits for a new start.
- R8: On the second matching address byte after reset, the strap value is stored and `addr_locked` goes to 1 and stays there. After that, strap changes have no effect on address matching.
- R9: Before the lock, matching uses the live strap pins.
- R10: `start_pulse` fires once per matching address byte, with `txn_rw` equal to the R/W bit.
- R11: After reset, `sda_oe`, `wr_valid`, `rd_req`, `start_pulse` and `addr_locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 3 | Low three address bits from pins |
| rd_data | input | 8 | Transmit byte, sampled in the cycle `rd_req` is 1 |
| wr_valid | output | 1 | One-cycle strobe for a received byte |
| wr_data | output | 8 | Received byte, valid with `wr_valid` |
| rd_req | output | 1 | One-cycle request for the next transmit byte |
| start_pulse | output | 1 | One-cycle mark of a matching address byte |
| txn_rw | output | 1 | R/W bit of the current transaction |
| addr_locked | output | 1 | Sticky: strap address has been frozen |

## Verification
The two synchronizer flops, the edge register and the output register together put every bus-facing result about four system clocks behind the SCL edge that causes it. The bench therefore holds each SCL phase for eight clocks and reads the line half-way through SCL high. `wr_valid`, `rd_req` and `start_pulse` follow the eighth or ninth rising SCL edge by the same few clocks, so monitors count them on every falling system-clock edge and compare the totals at the end of each scenario. The timeout result is due `TIMEOUT_CYC` plus a few clocks after the last SDA change, so the bench waits twenty clocks past that before it checks the release.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam logic [3:0] ADDR_HI = 4'b1001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_RNEXT
  } slv_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_edge,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_prev  = scl_sh[STAGES];
  assign sda_prev  = sda_sh[STAGES];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign sda_edge  = sda_lvl ^ sda_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2cs_idle_watch.sv
module i2cs_idle_watch #(
  parameter int TIMEOUT_CYC = 1500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic sda_edge,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  quiet <= '0;
    else if (!active || sda_edge) quiet <= '0;
    else if (quiet != LIMIT)     quiet <= quiet + 1'b1;
  end

  assign expire = active && (quiet == LIMIT);
endmodule

// File: rtl/i2cs_addr_latch.sv
module i2cs_addr_latch #(
  parameter int LOW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOW_W-1:0] strap,
  input  logic             match_hit,
  output logic [LOW_W-1:0] low_bits,
  output logic             locked
);
  logic             seen_once;
  logic [LOW_W-1:0] frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_once <= 1'b0;
      locked    <= 1'b0;
      frozen    <= '0;
    end else if (match_hit && !locked) begin
      if (seen_once) begin
        frozen <= strap;
        locked <= 1'b1;
      end else begin
        seen_once <= 1'b1;
      end
    end
  end

  assign low_bits = locked ? frozen : strap;
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2cs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               wr_valid,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               rd_req,
  output logic               start_pulse,
  output logic               txn_rw,
  output logic               addr_locked
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, sda_edge, start_det, stop_det;
  logic expire, match_hit, addr_ok, ack_on, rw;
  logic [STRAP_W-1:0] low_bits;
  slv_state_e st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] tx;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_edge(sda_edge),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_idle_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .active(st != ST_IDLE),
    .sda_edge(sda_edge), .expire(expire)
  );

  i2cs_addr_latch #(.LOW_W(STRAP_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .strap(strap), .match_hit(match_hit),
    .low_bits(low_bits), .locked(addr_locked)
  );

  assign addr_ok   = (shreg[6:3] == ADDR_HI) && (shreg[2:0] == low_bits);
  assign match_hit = (st == ST_ADDR) && scl_rise && (cnt == LAST_BIT) && addr_ok
                     && !expire && !start_det && !stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  cnt <= '0;  shreg <= '0;  tx <= '0;
      sda_oe <= 1'b0; ack_on <= 1'b0; rw <= 1'b0;
      wr_valid <= 1'b0; wr_data <= '0; rd_req <= 1'b0;
      start_pulse <= 1'b0; txn_rw <= 1'b0;
    end else begin
      wr_valid    <= 1'b0;
      rd_req      <= 1'b0;
      start_pulse <= 1'b0;
      if (rd_req) tx <= rd_data;
      if (expire) begin
        st <= ST_IDLE;  sda_oe <= 1'b0;
      end else if (start_det) begin
        st <= ST_ADDR;  cnt <= '0;  sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE;  sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            shreg <= {shreg[BYTE_W-3:0], sda_lvl};
            if (cnt == LAST_BIT) begin
              if (match_hit) begin
                st <= ST_ACK;  ack_on <= 1'b0;  rw <= sda_lvl;
                start_pulse <= 1'b1;  txn_rw <= sda_lvl;  rd_req <= sda_lvl;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_on) begin
              sda_oe <= 1'b1;  ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;  cnt <= '0;
              if (rw) begin
                sda_oe <= ~tx[BYTE_W-1];  st <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;  st <= ST_WDATA;
              end
            end
          end
          ST_WDATA: if (scl_rise) begin
            shreg <= {shreg[BYTE_W-3:0], sda_lvl};
            if (cnt == LAST_BIT) begin
              wr_valid <= 1'b1;  wr_data <= {shreg, sda_lvl};
              st <= ST_ACK;  ack_on <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RDATA: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == ALL_BITS) begin
                sda_oe <= 1'b0;  st <= ST_RACK;
              end else begin
                sda_oe <= ~tx[3'(LAST_BIT - cnt)];
              end
            end
          end
          ST_RACK: if (scl_rise) begin
            if (!sda_lvl) begin
              rd_req <= 1'b1;  st <= ST_RNEXT;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_RNEXT: if (scl_fall) begin
            sda_oe <= ~tx[BYTE_W-1];  cnt <= '0;  st <= ST_RDATA;
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_lvl,
  input logic wr_valid,
  input logic rd_req,
  input logic start_pulse,
  input logic addr_locked,
  input logic expire
);
  p_oe_rise_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);
  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  p_rdreq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  p_timeout_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !sda_oe);
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_locked |=> addr_locked);
  p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
endmodule

bind i2c_strap_slave i2cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .wr_valid(wr_valid), .rd_req(rd_req), .start_pulse(start_pulse),
  .addr_locked(addr_locked), .expire(expire)
);

// File: tb/test_i2c_strap_slave.sv
module test_i2c_strap_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int TMO = 500;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic [2:0] strap = 3'b010;
  logic [7:0] rd_data;
  logic sda_oe, wr_valid, rd_req, start_pulse, txn_rw, addr_locked;
  logic [7:0] wr_data;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int oe_hits = 0, wr_n = 0, rd_n = 0, st_n = 0;
  logic [7:0] wr_log [16];
  logic [7:0] rd_mem [8];
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_strap_slave #(.TIMEOUT_CYC(TMO)) i_i2c_strap_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .rd_data(rd_data), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .start_pulse(start_pulse), .txn_rw(txn_rw),
    .addr_locked(addr_locked)
  );

  assign rd_data = rd_mem[rd_n[2:0]];
  always @(posedge clk) if (rd_req) rd_n <= rd_n + 1;
  always @(negedge clk) begin
    if (sda_oe) oe_hits++;
    if (wr_valid) begin wr_log[wr_n[3:0]] = wr_data; wr_n++; end
    if (start_pulse) st_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1; wt(H); scl_m = 1; wt(H); sda_m = 0; wt(H); scl_m = 0; wt(H);
  endtask
  task automatic bus_stop;
    sda_m = 0; wt(H); scl_m = 1; wt(H); sda_m = 1; wt(H);
  endtask
  task automatic send_bit(input bit b);
    sda_m = b; wt(H); scl_m = 1; wt(H); scl_m = 0;
  endtask
  task automatic write_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; wt(H); scl_m = 1; wt(H/2); acked = !sda_line; wt(H/2); scl_m = 0;
  endtask
  task automatic read_byte(input bit master_nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wt(H); scl_m = 1; wt(H/2); b[i] = sda_line; wt(H/2); scl_m = 0;
    end
    send_bit(master_nack);
  endtask

  task automatic t_reset;
    chk(!sda_oe && !wr_valid && !rd_req && !start_pulse && !addr_locked, "R11 reset",
        {sda_oe, wr_valid, rd_req, start_pulse, addr_locked}, 0);
  endtask

  task automatic t_nomatch;
    bit a; int oe0 = oe_hits;
    strap = 3'b010;
    bus_start; write_byte(8'h96, a);
    chk(!a, "R2 no ack for 0x4B", a, 0);
    write_byte(8'h00, a); bus_stop;
    chk(oe_hits == oe0, "R2 sda released", oe_hits - oe0, 0);
    chk(st_n == 0 && wr_n == 0, "R10 no start/write on miss", st_n + wr_n, 0);
  endtask

  task automatic t_write_live;
    bit a;
    strap = 3'b011;
    bus_start; write_byte(8'h96, a);
    chk(a, "R9 R1 ack on live strap 011", a, 1);
    write_byte(8'hA5, a); chk(a, "R3 data ack", a, 1);
    write_byte(8'h3C, a); chk(a, "R3 data ack", a, 1);
    bus_stop;
    chk(wr_n == 2 && wr_log[0] == 8'hA5 && wr_log[1] == 8'h3C, "R3 write bytes",
        {wr_log[0], wr_log[1]}, 16'hA53C);
    chk(st_n == 1 && txn_rw == 0, "R10 start pulse write", {st_n[7:0], 7'd0, txn_rw}, 16'h0100);
    chk(!addr_locked, "R8 not locked after first", addr_locked, 0);
  endtask

  task automatic t_read_lock;
    bit a; logic [7:0] b0, b1, b2; int oe0;
    strap = 3'b010;
    bus_start; write_byte(8'h95, a);
    chk(a, "R9 R1 ack on live strap 010", a, 1);
    chk(addr_locked, "R8 locked on second match", addr_locked, 1);
    chk(st_n == 2 && txn_rw == 1, "R10 start pulse read", {st_n[7:0], 7'd0, txn_rw}, 16'h0201);
    read_byte(0, b0); read_byte(0, b1); read_byte(1, b2);
    chk({b0, b1, b2} == 24'h965AC3, "R4 read bytes", {b0, b1, b2}, 24'h965AC3);
    oe0 = oe_hits; send_bit(1);
    chk(oe_hits == oe0, "R5 released after NACK", oe_hits - oe0, 0);
    bus_stop;
    chk(rd_n == 3, "R5 R4 request count", rd_n, 3);
  endtask

  task automatic t_frozen;
    bit a;
    strap = 3'b101;
    bus_start; write_byte(8'h9A, a); bus_stop;
    chk(!a, "R8 pins ignored after lock", a, 0);
    bus_start; write_byte(8'h94, a);
    chk(a, "R8 stored address still matches", a, 1);
    write_byte(8'h11, a); bus_stop;
    chk(wr_n == 3 && wr_log[2] == 8'h11, "R8 write after lock", wr_log[2], 8'h11);
  endtask

  task automatic t_abort;
    bit a;
    bus_start; write_byte(8'h94, a);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    bus_start; write_byte(8'h94, a);
    chk(a, "R6 address after repeated start", a, 1);
    write_byte(8'h77, a); bus_stop;
    chk(wr_n == 4 && wr_log[3] == 8'h77, "R6 partial byte dropped", wr_n, 4);
  endtask

  task automatic t_timeout;
    bit a; int oe0;
    bus_start; write_byte(8'h95, a);
    wt(20);
    chk(sda_oe, "R4 driving MSB 0", sda_oe, 1);
    wt(TMO + 20);
    chk(!sda_oe, "R7 released after timeout", sda_oe, 0);
    oe0 = oe_hits; write_byte(8'hFF, a);
    chk(oe_hits == oe0, "R7 idle after timeout", oe_hits - oe0, 0);
    bus_stop;
  endtask

  initial begin
    rd_mem[0] = 8'h96; rd_mem[1] = 8'h5A; rd_mem[2] = 8'hC3; rd_mem[3] = 8'h00;
    for (int i = 4; i < 8; i++) rd_mem[i] = 8'hFF;
    wt(5); t_reset; rst_n = 1; wt(5);
    t_nomatch; t_write_live; t_read_lock; t_frozen; t_abort; t_timeout;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule